// File: doc/BRIEF.md
# CCK Chip Sequence Generator

This block turns each data symbol of a complementary code keying transmission into a code word of eight QPSK chips. In the high-rate mode it takes eight data bits per symbol. In the low-rate mode it takes four. From those bits it derives four quadrant phases and adds them modulo 4 over a generalized Hadamard pattern to form the eight chip phases. The first of the four phases is carried differentially from symbol to symbol. Each chip comes out as a 2-bit phase index and also as a pair of I/Q sign bits.

A symbol is loaded with a one-cycle `sym_load` pulse while `sym_ready` is high. The chips are then presented one at a time, and each `chip_en` pulse advances to the next chip. On the final chip, a new symbol can be loaded in the same cycle that consumes that chip, so symbols follow each other with no gap. The first symbol of a packet takes its phase reference from `start_phase`. Every later symbol uses the first phase of the symbol before it.

Top module: `cck_chip_gen`

## Requirements
- R1: `sym_ready` is high whenever no symbol is in flight. A `sym_load` pulse that comes while `sym_ready` is low is ignored: the chip index, the chip phase and the stored phase reference all stay unchanged. An accepted load shows chip 0 with `chip_valid` high at the next clock.
- R2: While a symbol is in flight, each `chip_en` advances `chip_idx` by one. Without `chip_en`, `chip_idx` and `chip_phase` hold their values.
- R3: The first phase p1 is the reference plus a step set by the dibit (d0,d1), where d0 is `sym_bits[0]` and d1 is `sym_bits[1]`. The steps are: 00 gives 0, 01 gives +1, 11 gives +2 and 10 gives +3 quadrants, all modulo 4.
- R4: When `pkt_first` is high at load, the reference is `start_phase`. Otherwise the reference is the p1 of the previous accepted symbol.
- R5: With `rate_hi`=1, p2={d3,d2}, p3={d5,d4} and p4={d7,d6}, where dn is `sym_bits[n]` and the first bit named is the MSB.
- R6: With `rate_hi`=0, p2=2·d2+1, p3=0 and p4=2·d3. Bits `sym_bits[7:4]` have no effect.
- R7: The chip phases c0 to c7, in output order, are: p1+p2+p3+p4, p1+p3+p4+1, p1+p2+p4, p1+p4+1, p1+p2+p3, p1+p3, p1+p2 and p1, all modulo 4.
- R8: Each phase maps to I/Q signs (1 = −1) as follows: 0 gives (+,+), 1 gives (−,+), 2 gives (−,−) and 3 gives (+,−).
- R9: After reset, and whenever idle, `chip_valid`=0, `chip_phase`=0, both sign bits are 0 and `sym_ready`=1.
- R10: `chip_en` on chip 7 ends the symbol, so `chip_valid` falls, unless a `sym_load` in the same cycle starts the next symbol at chip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_load | input | 1 | Load a symbol |
| rate_hi | input | 1 | 1: eight bits per symbol; 0: four bits per symbol |
| pkt_first | input | 1 | Symbol is the first of a packet |
| start_phase | input | 2 | Phase reference for the first symbol |
| sym_bits | input | 8 | Symbol data, d0 in bit 0 |
| chip_en | input | 1 | Consume the current chip |
| sym_ready | output | 1 | A load is accepted this cycle |
| chip_valid | output | 1 | A chip is being presented |
| chip_idx | output | 3 | Index of the current chip |
| chip_phase | output | 2 | Quadrant index of the current chip |
| chip_i_neg | output | 1 | I sign, 1 = −1 |
| chip_q_neg | output | 1 | Q sign, 1 = −1 |
| chip_last | output | 1 | Current chip is chip 7 |

## Verification
The assertions check the handshake and the sequencing on every cycle. This covers the acceptance of loads, the hold of a chip without `chip_en`, the single-step index advance, the end of a symbol and the quiet idle outputs. The actual phase values can only be shown by the bench's scenarios. These include the differential chaining of p1 across symbols, the restart from `start_phase`, both rate mappings with junk in the unused high bits, the rotation added to chips 1 and 3, and proof that a refused load leaves the reference untouched.

// File: rtl/cck_chip_gen.sv
module cck_chip_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_load,
  input  logic       rate_hi,
  input  logic       pkt_first,
  input  logic [1:0] start_phase,
  input  logic [7:0] sym_bits,
  input  logic       chip_en,
  output logic       sym_ready,
  output logic       chip_valid,
  output logic [2:0] chip_idx,
  output logic [1:0] chip_phase,
  output logic       chip_i_neg,
  output logic       chip_q_neg,
  output logic       chip_last
);
  localparam int NCHIP = 8;

  logic [1:0]         ref_q;
  logic               busy;
  logic [2:0]         idx;
  logic [2*NCHIP-1:0] word_q;
  logic [2*NCHIP-1:0] word_d;

  logic [1:0] step, base, p1, p2, p3, p4;
  logic       accept, adv;

  assign step = {sym_bits[0], sym_bits[0] ^ sym_bits[1]};
  assign base = pkt_first ? start_phase : ref_q;
  assign p1   = base + step;
  assign p2   = rate_hi ? sym_bits[3:2] : {sym_bits[2], 1'b1};
  assign p3   = rate_hi ? sym_bits[5:4] : 2'd0;
  assign p4   = rate_hi ? sym_bits[7:6] : {sym_bits[3], 1'b0};

  for (genvar k = 0; k < NCHIP; k++) begin : g_chip
    localparam logic [2:0] KB = 3'(k);
    localparam logic [1:0] ROT = (!KB[2] && KB[0]) ? 2'd1 : 2'd0;
    assign word_d[2*k +: 2] = p1 + (KB[0] ? 2'd0 : p2) + (KB[1] ? 2'd0 : p3)
                            + (KB[2] ? 2'd0 : p4) + ROT;
  end

  assign chip_last  = busy && (idx == 3'(NCHIP - 1));
  assign adv        = busy && chip_en;
  assign sym_ready  = !busy || (adv && chip_last);
  assign accept     = sym_load && sym_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
      ref_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx    <= '0;
      word_q <= word_d;
      ref_q  <= p1;
    end else if (adv) begin
      idx <= idx + 3'd1;
      if (chip_last) busy <= 1'b0;
    end
  end

  assign chip_valid = busy;
  assign chip_idx   = busy ? idx : 3'd0;
  assign chip_phase = busy ? word_q[{idx, 1'b0} +: 2] : 2'd0;
  assign chip_i_neg = chip_phase[1] ^ chip_phase[0];
  assign chip_q_neg = chip_phase[1];
endmodule

// File: rtl/cck_chip_gen_chk.sv
module cck_chip_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_load,
  input logic       chip_en,
  input logic       sym_ready,
  input logic       chip_valid,
  input logic [2:0] chip_idx,
  input logic [1:0] chip_phase,
  input logic       chip_i_neg,
  input logic       chip_q_neg,
  input logic       chip_last
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_load && sym_ready) |=> (chip_valid && chip_idx == 3'd0));

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> sym_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_en) |=> (chip_valid && $stable(chip_idx) && $stable(chip_phase)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && chip_en && !chip_last) |=> (chip_idx == $past(chip_idx) + 3'd1));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> (chip_phase == 2'd0 && !chip_i_neg && !chip_q_neg));

  assert_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_last && chip_en && !sym_load) |=> !chip_valid);
endmodule

bind cck_chip_gen cck_chip_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_load(sym_load), .chip_en(chip_en),
  .sym_ready(sym_ready), .chip_valid(chip_valid), .chip_idx(chip_idx),
  .chip_phase(chip_phase), .chip_i_neg(chip_i_neg), .chip_q_neg(chip_q_neg),
  .chip_last(chip_last)
);

// File: tb/cck_chip_gen_tb.sv
module cck_chip_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_load = 1'b0, rate_hi = 1'b0, pkt_first = 1'b0, chip_en = 1'b0;
  logic [1:0] start_phase = 2'd0;
  logic [7:0] sym_bits = 8'd0;
  logic       sym_ready, chip_valid, chip_i_neg, chip_q_neg, chip_last;
  logic [2:0] chip_idx;
  logic [1:0] chip_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cck_chip_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sym_load(sym_load), .rate_hi(rate_hi),
    .pkt_first(pkt_first), .start_phase(start_phase), .sym_bits(sym_bits),
    .chip_en(chip_en), .sym_ready(sym_ready), .chip_valid(chip_valid),
    .chip_idx(chip_idx), .chip_phase(chip_phase), .chip_i_neg(chip_i_neg),
    .chip_q_neg(chip_q_neg), .chip_last(chip_last)
  );

  // {pkt_first, start_phase, rate_hi, sym_bits, expected chips c7..c0, hold gap}
  typedef struct packed {
    logic        first;
    logic [1:0]  start;
    logic        rate;
    logic [7:0]  bits;
    logic [15:0] exp;
    logic        gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b1, 8'h00, 16'h0044, 1'b0},  // R7 base pattern, R4
    '{1'b0, 2'd0, 1'b1, 8'hE5, 16'hC6F5, 1'b1},  // R3 step 3, R5
    '{1'b0, 2'd0, 1'b0, 8'hF6, 16'h3377, 1'b0},  // R6 junk high nibble, R3 step 1
    '{1'b0, 2'd0, 1'b0, 8'h0D, 16'hEE88, 1'b1},  // R6
    '{1'b1, 2'd2, 1'b1, 8'h03, 16'h0044, 1'b0},  // R4 restart from start_phase
    '{1'b0, 2'd0, 1'b1, 8'hFF, 16'h9487, 1'b0},  // R5 all ones, R3 step 2
    '{1'b0, 2'd0, 1'b1, 8'h02, 16'hFF33, 1'b0}   // R3 step 1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_chip(input int k, input logic [1:0] ph);
    logic [1:0] iq;
    case (ph)
      2'd0: iq = 2'b00;
      2'd1: iq = 2'b10;
      2'd2: iq = 2'b11;
      default: iq = 2'b01;
    endcase
    chk(chip_valid === 1'b1, "R2 valid", int'(chip_valid), 1);
    chk(chip_idx === 3'(k), "R2 index", int'(chip_idx), k);
    chk(chip_phase === ph, "R7 phase", int'(chip_phase), int'(ph));
    chk({chip_i_neg, chip_q_neg} === iq, "R8 iq", int'({chip_i_neg, chip_q_neg}), int'(iq));
  endtask

  task automatic load(input logic f, input logic [1:0] s, input logic r, input logic [7:0] b);
    chk(sym_ready === 1'b1, "R1 ready", int'(sym_ready), 1);
    pkt_first = f; start_phase = s; rate_hi = r; sym_bits = b; sym_load = 1'b1;
    @(posedge clk); @(negedge clk);
    sym_load = 1'b0;
  endtask

  task automatic step();
    chip_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chip_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(chip_valid === 1'b0, "R9 valid", int'(chip_valid), 0);
    chk(sym_ready === 1'b1, "R9 ready", int'(sym_ready), 1);
    chk(chip_phase === 2'd0, "R9 phase", int'(chip_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VECS[v].first, VECS[v].start, VECS[v].rate, VECS[v].bits);
      for (int k = 0; k < 8; k++) begin
        chk_chip(k, VECS[v].exp[2*k +: 2]);
        if (VECS[v].gap) begin
          @(negedge clk);
          chk_chip(k, VECS[v].exp[2*k +: 2]);  // R2 hold without chip_en
        end
        step();
      end
      chk(chip_valid === 1'b0, "R10 end", int'(chip_valid), 0);
    end

    // R1: load while busy is ignored (reference 3 after last vector)
    load(1'b0, 2'd0, 1'b1, 8'h00);  // p1=3, chips c7..c0 = 16'hFF33
    for (int k = 0; k < 3; k++) step();
    chk_chip(3, 2'd0);
    pkt_first = 1'b1; start_phase = 2'd1; sym_bits = 8'hFF; sym_load = 1'b1;
    chk(sym_ready === 1'b0, "R1 busy not ready", int'(sym_ready), 0);
    @(posedge clk); @(negedge clk);
    sym_load = 1'b0;
    chk_chip(3, 2'd0);  // R1 ignored load
    for (int k = 3; k < 7; k++) step();
    chk_chip(7, 2'd3);

    // R10 back to back: reference must still be 3 -> p1 = 3+3 = 2
    pkt_first = 1'b0; rate_hi = 1'b1; sym_bits = 8'h01; sym_load = 1'b1; chip_en = 1'b1;
    chk(sym_ready === 1'b1, "R10 ready on last", int'(sym_ready), 1);
    @(posedge clk); @(negedge clk);
    sym_load = 1'b0; chip_en = 1'b0;
    chk_chip(0, 2'd2);  // R10, R1 reference unchanged by refused load
    step();
    chk_chip(1, 2'd3);

    // R9 reset mid-symbol
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(chip_valid === 1'b0, "R9 reset valid", int'(chip_valid), 0);
    chk({chip_i_neg, chip_q_neg} === 2'b00, "R9 reset iq", int'({chip_i_neg, chip_q_neg}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule